// File: doc/BRIEF.md
# Sector Protection and Erase Gate

This block is the write gatekeeper of a serial flash controller. Each cycle it may take one decoded command: a page program, an erase of one of three block sizes, a whole-array erase, or one of the commands that change sector protection. For array-changing commands it works out the affected region as an aligned start address, a byte length and the address of the last byte touched. It then decides whether the operation may go ahead. The array write, the erase timing and any security register are handled elsewhere.

The array has 1 MiB and is split into 16 sectors of 64 KiB. Three layers guard each sector:
- A soft protect bit that software can set and clear.
- The write-protect input, which freezes the protect bits while it is low.
- A lockdown bit that only goes one way in normal use.

Protect bits come up set after reset. Lockdown bits are not touched by reset; only a test hook clears them. A sticky error flag records that the most recent command was refused.

Top module: `sector_gate`

## Requirements
- R1: After reset, resp_valid and err_flag are low and all 16 protect bits are set, so every program or erase is refused until protection is lifted.
- R2: Opcodes 20h, 52h and D8h erase 4 KiB, 32 KiB and 64 KiB respectively. resp_start is the address with bits 23:20 forced to zero and its low 12, 15 or 16 bits cleared. resp_len is the block size in bytes, and resp_last equals resp_start + resp_len - 1.
- R3: Opcode C7h erases the whole array and reports start 0, length 2^20 and last 0FFFFFh. It is allowed only when no sector has its protect or lockdown bit set.
- R4: Opcode 02h programs cmd_nbytes bytes. resp_start is the address with bits 23:20 forced to zero, and resp_len is cmd_nbytes. resp_last keeps the page bits of the start and takes (start[7:0] + cmd_nbytes - 1) mod 256 as its low byte, so the write wraps inside its 256-byte page. A count of 0 or above 256 is refused.
- R5: A program or block erase is refused if the sector at address bits 19:16 has its protect or lockdown bit set, and allowed otherwise.
- R6: Opcode E1h sets and E2h clears the protect bit of the sector at bits 19:16. E3h sets all protect bits and E4h clears all of them.
- R7: While wp_n is low, E1h, E2h, E3h and E4h are refused and leave every protect bit unchanged.
- R8: Opcode E5h sets the lockdown bit of the addressed sector whatever the level of wp_n. The following cannot clear a lockdown bit: E2h on that sector (which is refused), E4h, or reset. Only lock_clear clears lockdown bits.
- R9: err_flag is set by every refused command, is cleared by every allowed command, and holds its value while no command arrives.
- R10: Any opcode not listed above is refused and reports zero start, length and last.
- R11: resp_valid is high for exactly one cycle, in the cycle after each cycle where cmd_valid is high. The result fields hold until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_clear | input | 1 | Test hook that clears all lockdown bits |
| wp_n | input | 1 | Write-protect level; low freezes protect bits |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 8 | Command opcode |
| cmd_addr | input | 24 | Command byte address |
| cmd_nbytes | input | 9 | Program byte count, 1 to 256 |
| resp_valid | output | 1 | Result strobe |
| resp_allow | output | 1 | Command accepted |
| resp_start | output | 24 | Aligned start of affected region |
| resp_last | output | 24 | Address of last affected byte |
| resp_len | output | 21 | Length of affected region in bytes |
| err_flag | output | 1 | Sticky refusal flag |

## Verification
The assertions assume three things about the inputs. First, cmd_code, cmd_addr, cmd_nbytes and wp_n are known in every cycle where cmd_valid is high. Second, lock_clear is pulsed together with the first reset, so the non-resettable lockdown bits start from a known value. Third, wp_n changes only between clock edges. The bench holds lock_clear during the first reset and changes every input on the falling clock edge. It sweeps every sector under all three erase sizes with several address offsets, and it sweeps page offsets against counts that include the wrap, the full page and the two illegal counts.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam logic [7:0] OP_PROG        = 8'h02;
    localparam logic [7:0] OP_ER4K        = 8'h20;
    localparam logic [7:0] OP_ER32K       = 8'h52;
    localparam logic [7:0] OP_ER64K       = 8'hD8;
    localparam logic [7:0] OP_CHIP        = 8'hC7;
    localparam logic [7:0] OP_SECT_PROT   = 8'hE1;
    localparam logic [7:0] OP_SECT_UNPROT = 8'hE2;
    localparam logic [7:0] OP_ALL_PROT    = 8'hE3;
    localparam logic [7:0] OP_ALL_UNPROT  = 8'hE4;
    localparam logic [7:0] OP_LOCKDOWN    = 8'hE5;

    typedef enum logic [2:0] {
        K_NONE,
        K_PROG,
        K_ERASE,
        K_CHIP,
        K_CTRL
    } kind_e;
endpackage

// File: rtl/sg_region.sv
module sg_region
    import sg_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int ARRAY_W = 20,
    parameter int SECT_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int BLK_S_W = 12,
    parameter int BLK_M_W = 15,
    parameter int IDX_W   = 4,
    parameter int LEN_W   = 21
) (
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [PAGE_W:0]   cmd_nbytes,
    output kind_e             kind,
    output logic [IDX_W-1:0]  sect,
    output logic [ADDR_W-1:0] start,
    output logic [ADDR_W-1:0] last,
    output logic [LEN_W-1:0]  len,
    output logic              nbytes_ok
);
    localparam logic [PAGE_W:0] PAGE_BYTES = {1'b1, {PAGE_W{1'b0}}};

    logic [ADDR_W-1:0] base;
    logic [PAGE_W-1:0] tail;
    logic              unused_hi;

    assign unused_hi = ^cmd_addr[ADDR_W-1:ARRAY_W];
    assign sect      = cmd_addr[ARRAY_W-1:SECT_W];
    assign nbytes_ok = (cmd_nbytes != '0) && (cmd_nbytes <= PAGE_BYTES);

    always_comb begin
        base  = ADDR_W'(cmd_addr[ARRAY_W-1:0]);
        tail  = base[PAGE_W-1:0] + cmd_nbytes[PAGE_W-1:0] - PAGE_W'(1);
        kind  = K_NONE;
        start = '0;
        last  = '0;
        len   = '0;
        case (cmd_code)
            OP_PROG: begin
                kind  = K_PROG;
                start = base;
                len   = LEN_W'(cmd_nbytes);
                last  = {base[ADDR_W-1:PAGE_W], tail};
            end
            OP_ER4K: begin
                kind = K_ERASE;
                len  = LEN_W'(1) << BLK_S_W;
            end
            OP_ER32K: begin
                kind = K_ERASE;
                len  = LEN_W'(1) << BLK_M_W;
            end
            OP_ER64K: begin
                kind = K_ERASE;
                len  = LEN_W'(1) << SECT_W;
            end
            OP_CHIP: begin
                kind = K_CHIP;
                len  = LEN_W'(1) << ARRAY_W;
            end
            OP_SECT_PROT, OP_SECT_UNPROT, OP_ALL_PROT,
            OP_ALL_UNPROT, OP_LOCKDOWN: kind = K_CTRL;
            default: kind = K_NONE;
        endcase
        if (kind == K_ERASE || kind == K_CHIP) begin
            start = base & ~(ADDR_W'(len) - ADDR_W'(1));
            last  = start + ADDR_W'(len) - ADDR_W'(1);
        end
    end
endmodule

// File: rtl/sg_prot.sv
module sg_prot
    import sg_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int NSECT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_clear,
    input  logic             wp_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [IDX_W-1:0] sect,
    output logic [NSECT-1:0] blocked,
    output logic             ctrl_ok
);
    logic [NSECT-1:0] prot_d, prot_q;
    logic [NSECT-1:0] lock_d, lock_q;

    always_comb begin
        prot_d  = prot_q;
        lock_d  = lock_q;
        ctrl_ok = 1'b0;
        case (cmd_code)
            OP_SECT_PROT: begin
                ctrl_ok = wp_n;
                if (cmd_valid && ctrl_ok) prot_d[sect] = 1'b1;
            end
            OP_SECT_UNPROT: begin
                ctrl_ok = wp_n && !lock_q[sect];
                if (cmd_valid && ctrl_ok) prot_d[sect] = 1'b0;
            end
            OP_ALL_PROT: begin
                ctrl_ok = wp_n;
                if (cmd_valid && ctrl_ok) prot_d = '1;
            end
            OP_ALL_UNPROT: begin
                ctrl_ok = wp_n;
                if (cmd_valid && ctrl_ok) prot_d = '0;
            end
            OP_LOCKDOWN: begin
                ctrl_ok = 1'b1;
                if (cmd_valid) lock_d[sect] = 1'b1;
            end
            default: ctrl_ok = 1'b0;
        endcase
    end

    assign blocked = prot_q | lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= '1;
        else        prot_q <= prot_d;
    end

    always_ff @(posedge clk) begin
        if (lock_clear) lock_q <= '0;
        else            lock_q <= lock_d;
    end

    // R8
    lock_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_clear |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

    // R7
    wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> $stable(prot_q));
endmodule

// File: rtl/sector_gate.sv
module sector_gate
    import sg_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int ARRAY_W = 20,
    parameter int SECT_W  = 16,
    parameter int PAGE_W  = 8,
    parameter int BLK_S_W = 12,
    parameter int BLK_M_W = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_clear,
    input  logic                 wp_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_code,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [PAGE_W:0]      cmd_nbytes,
    output logic                 resp_valid,
    output logic                 resp_allow,
    output logic [ADDR_W-1:0]    resp_start,
    output logic [ADDR_W-1:0]    resp_last,
    output logic [ARRAY_W:0]     resp_len,
    output logic                 err_flag
);
    localparam int IDX_W = ARRAY_W - SECT_W;
    localparam int NSECT = 1 << IDX_W;
    localparam int LEN_W = ARRAY_W + 1;

    typedef struct packed {
        logic              valid;
        logic              allow;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] last;
        logic [LEN_W-1:0]  len;
        logic              err;
    } resp_t;

    kind_e             kind;
    logic [IDX_W-1:0]  sect;
    logic [ADDR_W-1:0] rg_start, rg_last;
    logic [LEN_W-1:0]  rg_len;
    logic              nbytes_ok;
    logic [NSECT-1:0]  blocked;
    logic              ctrl_ok;
    logic              allow;
    resp_t             r_d, r_q;

    sg_region #(
        .ADDR_W(ADDR_W), .ARRAY_W(ARRAY_W), .SECT_W(SECT_W), .PAGE_W(PAGE_W),
        .BLK_S_W(BLK_S_W), .BLK_M_W(BLK_M_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_region (
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
        .kind(kind), .sect(sect), .start(rg_start), .last(rg_last),
        .len(rg_len), .nbytes_ok(nbytes_ok)
    );

    sg_prot #(.IDX_W(IDX_W), .NSECT(NSECT)) u_prot (
        .clk(clk), .rst_n(rst_n), .lock_clear(lock_clear), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .sect(sect),
        .blocked(blocked), .ctrl_ok(ctrl_ok)
    );

    always_comb begin
        case (kind)
            K_PROG:  allow = nbytes_ok && !blocked[sect];
            K_ERASE: allow = !blocked[sect];
            K_CHIP:  allow = (blocked == '0);
            K_CTRL:  allow = ctrl_ok;
            default: allow = 1'b0;
        endcase
        r_d       = r_q;
        r_d.valid = cmd_valid;
        if (cmd_valid) begin
            r_d.allow = allow;
            r_d.start = rg_start;
            r_d.last  = rg_last;
            r_d.len   = rg_len;
            r_d.err   = !allow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign resp_valid = r_q.valid;
    assign resp_allow = r_q.allow;
    assign resp_start = r_q.start;
    assign resp_last  = r_q.last;
    assign resp_len   = r_q.len;
    assign err_flag   = r_q.err;

    // R11
    resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> resp_valid);
    // R11
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !resp_valid);
    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(err_flag));
    // R9
    err_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (err_flag == !resp_allow));
    // R2
    er4k_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_ER4K) |=>
        (resp_start[BLK_S_W-1:0] == '0 && resp_len == (LEN_W'(1) << BLK_S_W)));
    // R3
    chip_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_CHIP) |=>
        (resp_start == '0 && resp_len == (LEN_W'(1) << ARRAY_W)));
    // R4
    prog_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_PROG) |=>
        (resp_last[ADDR_W-1:PAGE_W] == resp_start[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/sector_gate_test.sv
`timescale 1ns/1ps
module sector_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_clear = 1'b1;
    logic        wp_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [23:0] cmd_addr = 24'h0;
    logic [8:0]  cmd_nbytes = 9'h0;
    logic        resp_valid, resp_allow, err_flag;
    logic [23:0] resp_start, resp_last;
    logic [20:0] resp_len;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_prot, m_lock;
    logic        m_err;

    always #10 clk = ~clk;

    sector_gate uut (
        .clk(clk), .rst_n(rst_n), .lock_clear(lock_clear), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .cmd_nbytes(cmd_nbytes), .resp_valid(resp_valid), .resp_allow(resp_allow),
        .resp_start(resp_start), .resp_last(resp_last), .resp_len(resp_len),
        .err_flag(err_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [7:0] code,
                         input logic [23:0] addr, input logic [8:0] n);
        logic [3:0]  s;
        logic [23:0] base, st, la;
        logic [20:0] ln;
        logic        al, region;
        s = addr[19:16];
        base = {4'h0, addr[19:0]};
        st = 0; la = 0; ln = 0; al = 0; region = 1'b1;
        case (code)
            8'h02: begin
                st = base; ln = 21'(n);
                la = {base[23:8], 8'(base[7:0] + n - 9'd1)};
                al = (n >= 1) && (n <= 256) && !(m_prot[s] | m_lock[s]);
            end
            8'h20, 8'h52, 8'hD8: begin
                ln = (code == 8'h20) ? 21'd4096 : (code == 8'h52) ? 21'd32768 : 21'd65536;
                st = base - (base % 24'(ln));
                la = st + 24'(ln) - 24'd1;
                al = !(m_prot[s] | m_lock[s]);
            end
            8'hC7: begin
                st = 0; ln = 21'h100000; la = 24'h0FFFFF;
                al = ((m_prot | m_lock) == 16'h0);
            end
            default: region = 1'b0;
        endcase
        if (!region) begin
            case (code)
                8'hE1: begin al = wp_n; if (al) m_prot[s] = 1'b1; end
                8'hE2: begin al = wp_n && !m_lock[s]; if (al) m_prot[s] = 1'b0; end
                8'hE3: begin al = wp_n; if (al) m_prot = 16'hFFFF; end
                8'hE4: begin al = wp_n; if (al) m_prot = 16'h0; end
                8'hE5: begin al = 1'b1; m_lock[s] = 1'b1; end
                default: al = 1'b0;
            endcase
        end
        m_err = !al;
        cmd_valid = 1'b1; cmd_code = code; cmd_addr = addr; cmd_nbytes = n;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(tag, "resp_valid", 32'(resp_valid), 32'd1);
        chk(tag, "resp_allow", 32'(resp_allow), 32'(al));
        chk(tag, "err_flag", 32'(err_flag), 32'(m_err));
        chk(tag, "resp_start", 32'(resp_start), 32'(st));
        chk(tag, "resp_last", 32'(resp_last), 32'(la));
        chk(tag, "resp_len", 32'(resp_len), 32'(ln));
    endtask

    task automatic idle(input string tag, input int cyc);
        repeat (cyc) @(negedge clk);
        chk(tag, "idle resp_valid", 32'(resp_valid), 32'd0);
        chk(tag, "idle err_flag", 32'(err_flag), 32'(m_err));
    endtask

    task automatic do_reset(input logic clr);
        rst_n = 1'b0; lock_clear = clr;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; lock_clear = 1'b0;
        m_prot = 16'hFFFF; m_err = 1'b0;
        if (clr) m_lock = 16'h0;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL R11 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        // R1 reset state
        chk("R1", "resp_valid", 32'(resp_valid), 32'd0);
        chk("R1", "err_flag", 32'(err_flag), 32'd0);
        for (int s = 0; s < 16; s++) drive("R1", 8'hD8, {4'h0, 4'(s), 16'h1234}, 9'd0);
        // R7 global unprotect refused under wp low
        wp_n = 1'b0;
        drive("R7", 8'hE4, 24'h0, 9'd0);
        drive("R7", 8'h20, 24'h030000, 9'd0);
        wp_n = 1'b1;
        drive("R6", 8'hE4, 24'h0, 9'd0);
        // R2 sweep over sectors, sizes and offsets
        for (int s = 0; s < 16; s++)
            for (int k = 0; k < 3; k++) begin
                logic [7:0] op;
                op = (k == 0) ? 8'h20 : (k == 1) ? 8'h52 : 8'hD8;
                drive("R2", op, {4'(s + k), 4'(s), 16'(s * 16'h1357 + k * 16'h2A4B)}, 9'd0);
                drive("R2", op, {4'hF, 4'(s), 16'hFFFF}, 9'd0);
            end
        drive("R3", 8'hC7, 24'hABCDEF, 9'd0);
        // R5 / R6 per-sector protect
        drive("R6", 8'hE1, 24'h05_0000, 9'd0);
        drive("R3", 8'hC7, 24'h0, 9'd0);
        drive("R5", 8'h52, 24'h05_8123, 9'd0);
        drive("R5", 8'h52, 24'h06_8123, 9'd0);
        drive("R5", 8'h02, 24'h05_0010, 9'd4);
        wp_n = 1'b0;
        drive("R7", 8'hE2, 24'h05_0000, 9'd0);
        drive("R7", 8'hE1, 24'h07_0000, 9'd0);
        drive("R7", 8'hE3, 24'h0, 9'd0);
        drive("R7", 8'h20, 24'h07_0000, 9'd0);
        wp_n = 1'b1;
        drive("R6", 8'hE2, 24'h05_0000, 9'd0);
        drive("R5", 8'h20, 24'h05_F000, 9'd0);
        // R4 page program sweep
        for (int off = 0; off < 256; off += 17)
            for (int j = 0; j < 6; j++) begin
                logic [8:0] n;
                n = (j == 0) ? 9'd1 : (j == 1) ? 9'd16 : (j == 2) ? 9'd200 :
                    (j == 3) ? 9'd256 : (j == 4) ? 9'd0 : 9'd257;
                drive("R4", 8'h02, {4'h3, 4'h2, 8'h3C, 8'(off)}, n);
            end
        // R8 lockdown
        wp_n = 1'b0;
        drive("R8", 8'hE5, 24'h09_0000, 9'd0);
        wp_n = 1'b1;
        drive("R8", 8'hD8, 24'h09_4000, 9'd0);
        drive("R8", 8'hE2, 24'h09_0000, 9'd0);
        drive("R8", 8'hE4, 24'h0, 9'd0);
        drive("R8", 8'h20, 24'h09_1000, 9'd0);
        drive("R8", 8'h20, 24'h08_1000, 9'd0);
        drive("R3", 8'hC7, 24'h0, 9'd0);
        do_reset(1'b0);
        drive("R1", 8'h20, 24'h08_1000, 9'd0);
        drive("R8", 8'hE4, 24'h0, 9'd0);
        drive("R8", 8'h02, 24'h09_00F0, 9'd32);
        drive("R8", 8'h02, 24'h08_00F0, 9'd32);
        do_reset(1'b1);
        drive("R8", 8'hE4, 24'h0, 9'd0);
        drive("R8", 8'hD8, 24'h09_0000, 9'd0);
        // R10 unknown opcodes, R9 stickiness
        drive("R10", 8'h99, 24'h01_2345, 9'd5);
        idle("R9", 5);
        drive("R10", 8'h03, 24'h0, 9'd1);
        drive("R9", 8'h20, 24'h0, 9'd0);
        idle("R9", 3);
        idle("R11", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule